// File: doc/BRIEF.md
# Snooping write-invalidate coherence controller

This block models several private single-line caches that share one bus and keep one shared memory word coherent. Each cache controller takes read and write requests from its own processor. A read on a valid line is served locally. A read on an invalid line goes on the bus as a read miss. A write on a line that is not already dirty and exclusive first broadcasts an invalidate. Every controller watches the transactions of the others. It drops its copy when another controller invalidates. When it holds the only dirty copy and another controller misses, it hands that copy over.

Every pending request, hit or miss, waits for one bus slot. A round-robin arbiter grants one slot per cycle, so all accesses to the word fall into one global order. A one-word backing memory is included. It is refreshed whenever a dirty owner supplies its data. A processor sees `busy` while its request waits and a one-cycle `done` when the request finishes. A registered trace of the granted transaction lets the surrounding system follow the bus order.

Top module: `coh_snoop_top`

## Requirements
- R1: After synchronous reset every line is Invalid, `busy` and `done` are 0, `rd_data` is 0, `trace_op` is 0 (idle), `trace_src` is 0 and `mem_data` equals MEM_INIT.
- R2: A request is accepted at a clock edge where `req_valid[i]` is 1 and `busy[i]` is 0. From that edge `busy[i]` is 1 until the edge where the request is granted. After that edge `done[i]` is 1 for exactly one cycle and `busy[i]` is 0. Without contention, `done` appears in the second cycle after the accepting edge.
- R3: A read on an Invalid line issues a read miss, traced as `trace_op` = 1 with `trace_src` = requester. A read on a Shared or Modified line is traced as a local access, `trace_op` = 3.
- R4: A write on an Invalid or Shared line broadcasts an invalidate, traced as `trace_op` = 2, and leaves the writer Modified. A write on a Modified line is a local access (`trace_op` = 3) and sends nothing to the other controllers.
- R5: When an invalidate from another controller is seen, a controller drops its copy. Its next read is a read miss (`trace_op` = 1).
- R6: A read miss while another controller holds the line Modified returns the owner's data. The same transaction writes that data into memory, visible on `mem_data` in the same cycle as `done`. The owner becomes Shared, so its next write is an invalidate.
- R7: A read miss while no controller holds the line Modified returns `mem_data`.
- R8: One transaction is granted per cycle. The search starts at the index after the last granted one and wraps around. After reset, index 0 has the highest priority.
- R9: Every completed read returns the value of the most recent write before it in the bus order, or MEM_INIT if there was no such write.
- R10: An invalidate that overtakes a Modified copy discards that copy and leaves `mem_data` unchanged.
- R11: At any time at most one line is Modified, and a Modified line is the only valid copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCORE | Per-processor request strobe |
| req_write | input | NCORE | 1 = write, 0 = read, per processor |
| req_wdata | input | NCORE*DW | Write data, processor i in bits [i*DW +: DW] |
| busy | output | NCORE | Request pending, new requests ignored |
| done | output | NCORE | One-cycle completion pulse |
| rd_data | output | NCORE*DW | Last read result per processor |
| trace_op | output | 2 | Granted transaction of the last cycle: 0 idle, 1 read miss, 2 invalidate, 3 local |
| trace_src | output | $clog2(NCORE) | Index granted in the last cycle (0 when idle) |
| mem_data | output | DW | Backing memory word |

## Verification
A wrong line state shows up at the ports within one bus slot. A copy that missed an invalidate returns stale data on its next read and is traced as a local access where a read miss was due. An owner that failed to step down to Shared is traced as a local write instead of an invalidate. A lost flush shows as a `mem_data` mismatch in the cycle of the read miss. A wrong arbitration pointer changes `trace_src` and the `done` order in the very next contended cycle. The bench therefore compares every output against a behavioural model on every clock.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BOP_IDLE   = 2'd0,
    BOP_RDMISS = 2'd1,
    BOP_INVAL  = 2'd2,
    BOP_LOCAL  = 2'd3
  } bus_op_e;

endpackage

// File: rtl/coh_rr_arb.sv
`timescale 1ns/1ps
module coh_rr_arb #(
  parameter int NREQ  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREQ-1:0]  req,
  output logic [NREQ-1:0]  gnt,
  output logic             gnt_any,
  output logic [IDX_W-1:0] gnt_idx
);

  logic [IDX_W-1:0] last_q;

  always_comb begin
    int cand;
    gnt     = '0;
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int k = 1; k <= NREQ; k++) begin
      cand = (int'(last_q) + k) % NREQ;
      if (!gnt_any && req[cand]) begin
        gnt_any   = 1'b1;
        gnt[cand] = 1'b1;
        gnt_idx   = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= IDX_W'(NREQ - 1);
    end else if (gnt_any) begin
      last_q <= gnt_idx;
    end
  end

  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  // R8
  grant_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_any |-> ((gnt & req) == gnt));

  // R8
  no_idle_with_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> gnt_any);

endmodule

// File: rtl/coh_line_ctrl.sv
`timescale 1ns/1ps
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int DW    = 8,
  parameter int SRC_W = 2,
  parameter int ID    = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [DW-1:0]    req_wdata,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rd_data,
  output logic             bus_req,
  input  logic             gnt,
  input  bus_op_e          bus_op,
  input  logic [SRC_W-1:0] bus_src,
  input  logic [DW-1:0]    bus_fill,
  output bus_op_e          my_op,
  output logic             is_dirty,
  output logic             is_valid,
  output logic [DW-1:0]    line_data
);

  line_st_e      st_q;
  logic          pend_q;
  logic          wr_q;
  logic [DW-1:0] wd_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] rd_q;
  logic          done_q;
  logic          from_other;
  logic          snoop_inv;
  logic          snoop_rd;

  always_comb begin
    if (!pend_q) begin
      my_op = BOP_IDLE;
    end else if (wr_q) begin
      my_op = (st_q == LN_MOD) ? BOP_LOCAL : BOP_INVAL;
    end else begin
      my_op = (st_q == LN_INV) ? BOP_RDMISS : BOP_LOCAL;
    end
  end

  assign from_other = (bus_src != SRC_W'(ID));
  assign snoop_inv  = from_other && (bus_op == BOP_INVAL);
  assign snoop_rd   = from_other && (bus_op == BOP_RDMISS);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= LN_INV;
      pend_q <= 1'b0;
      wr_q   <= 1'b0;
      wd_q   <= '0;
      data_q <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!pend_q) begin
        if (req_valid) begin
          pend_q <= 1'b1;
          wr_q   <= req_write;
          wd_q   <= req_wdata;
        end
      end else if (gnt) begin
        pend_q <= 1'b0;
        done_q <= 1'b1;
        case (my_op)
          BOP_LOCAL: begin
            if (wr_q) data_q <= wd_q;
            else      rd_q   <= data_q;
          end
          BOP_INVAL: begin
            st_q   <= LN_MOD;
            data_q <= wd_q;
          end
          BOP_RDMISS: begin
            st_q   <= LN_SHR;
            data_q <= bus_fill;
            rd_q   <= bus_fill;
          end
          default: ;
        endcase
      end
      if (snoop_inv) begin
        st_q <= LN_INV;
      end else if (snoop_rd && st_q == LN_MOD) begin
        st_q <= LN_SHR;
      end
    end
  end

  assign busy      = pend_q;
  assign done      = done_q;
  assign rd_data   = rd_q;
  assign bus_req   = pend_q;
  assign is_dirty  = (st_q == LN_MOD);
  assign is_valid  = (st_q != LN_INV);
  assign line_data = data_q;

  // R5
  snoop_drop_chk: assert property (@(posedge clk) disable iff (rst)
    snoop_inv |=> (st_q == LN_INV));

  // R6
  owner_step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (snoop_rd && is_dirty) |=> (st_q == LN_SHR));

  // R3
  miss_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt && my_op == BOP_RDMISS) |=> (st_q == LN_SHR && rd_q == $past(bus_fill)));

  // R2
  done_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($past(pend_q) && !pend_q));

endmodule

// File: rtl/coh_mem.sv
`timescale 1ns/1ps
module coh_mem #(
  parameter int          DW   = 8,
  parameter int unsigned INIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= DW'(INIT);
    end else if (wr_en) begin
      word_q <= wr_data;
    end
  end

  assign rd_data = word_q;

  // R6
  flush_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (word_q == $past(wr_data)));

endmodule

// File: rtl/coh_snoop_top.sv
`timescale 1ns/1ps
module coh_snoop_top
  import coh_pkg::*;
#(
  parameter int          NCORE    = 4,
  parameter int          DW       = 8,
  parameter int unsigned MEM_INIT = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NCORE-1:0]           req_valid,
  input  logic [NCORE-1:0]           req_write,
  input  logic [NCORE*DW-1:0]        req_wdata,
  output logic [NCORE-1:0]           busy,
  output logic [NCORE-1:0]           done,
  output logic [NCORE*DW-1:0]        rd_data,
  output logic [1:0]                 trace_op,
  output logic [$clog2(NCORE)-1:0]   trace_src,
  output logic [DW-1:0]              mem_data
);

  localparam int SRC_W = $clog2(NCORE);

  logic [NCORE-1:0] bus_req;
  logic [NCORE-1:0] gnt;
  logic             gnt_any;
  logic [SRC_W-1:0] gnt_idx;
  logic [NCORE-1:0] dirty_vec;
  logic [NCORE-1:0] valid_vec;
  logic [DW-1:0]    line_data [NCORE];
  bus_op_e          ctl_op    [NCORE];
  bus_op_e          bus_op;
  logic [SRC_W-1:0] bus_src;
  logic [DW-1:0]    owner_data;
  logic [DW-1:0]    bus_fill;
  logic             flush;
  logic [1:0]       trace_op_q;
  logic [SRC_W-1:0] trace_src_q;

  coh_rr_arb #(.NREQ(NCORE), .IDX_W(SRC_W)) i_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (bus_req),
    .gnt     (gnt),
    .gnt_any (gnt_any),
    .gnt_idx (gnt_idx)
  );

  for (genvar g = 0; g < NCORE; g++) begin : g_ctl
    coh_line_ctrl #(.DW(DW), .SRC_W(SRC_W), .ID(g)) i_ctl (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid[g]),
      .req_write (req_write[g]),
      .req_wdata (req_wdata[g*DW +: DW]),
      .busy      (busy[g]),
      .done      (done[g]),
      .rd_data   (rd_data[g*DW +: DW]),
      .bus_req   (bus_req[g]),
      .gnt       (gnt[g]),
      .bus_op    (bus_op),
      .bus_src   (bus_src),
      .bus_fill  (bus_fill),
      .my_op     (ctl_op[g]),
      .is_dirty  (dirty_vec[g]),
      .is_valid  (valid_vec[g]),
      .line_data (line_data[g])
    );
  end

  always_comb begin
    bus_op = BOP_IDLE;
    for (int i = 0; i < NCORE; i++) begin
      if (gnt[i]) bus_op = ctl_op[i];
    end
  end

  assign bus_src = gnt_any ? gnt_idx : '0;

  always_comb begin
    owner_data = '0;
    for (int i = 0; i < NCORE; i++) begin
      if (dirty_vec[i]) owner_data = owner_data | line_data[i];
    end
  end

  assign bus_fill = (dirty_vec != '0) ? owner_data : mem_data;
  assign flush    = (bus_op == BOP_RDMISS) && (dirty_vec != '0);

  coh_mem #(.DW(DW), .INIT(MEM_INIT)) i_mem (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (flush),
    .wr_data (owner_data),
    .rd_data (mem_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trace_op_q  <= 2'd0;
      trace_src_q <= '0;
    end else begin
      trace_op_q  <= bus_op;
      trace_src_q <= bus_src;
    end
  end

  assign trace_op  = trace_op_q;
  assign trace_src = trace_src_q;

  // R11
  single_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dirty_vec) && ((dirty_vec == '0) || (valid_vec == dirty_vec)));

  // R10
  overtake_keeps_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_op == BOP_INVAL) |=> $stable(mem_data));

endmodule

// File: tb/test_coh_snoop_top.sv
`timescale 1ns/1ps
module test_coh_snoop_top;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int SW = 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_write = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0]    busy;
  logic [N-1:0]    done;
  logic [N*DW-1:0] rd_data;
  logic [1:0]      trace_op;
  logic [SW-1:0]   trace_src;
  logic [DW-1:0]   mem_data;

  always #2.5 clk = ~clk;

  coh_snoop_top #(.NCORE(N), .DW(DW), .MEM_INIT(0)) i_coh_snoop_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .trace_op(trace_op), .trace_src(trace_src), .mem_data(mem_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: 0 invalid, 1 shared, 2 modified
  int m_st[N], m_data[N], m_pend[N], m_wr[N], m_wd[N], m_rd[N], m_done[N];
  int m_mem, m_last, m_top, m_tsrc;

  always @(posedge clk) begin
    int g;
    int own;
    int val;
    int was_pend[N];
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_st[i] = 0; m_data[i] = 0; m_pend[i] = 0; m_wr[i] = 0;
        m_wd[i] = 0; m_rd[i] = 0; m_done[i] = 0;
      end
      m_mem = 0; m_last = N - 1; m_top = 0; m_tsrc = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        was_pend[i] = m_pend[i];
        m_done[i] = 0;
      end
      g = -1;
      for (int k = 1; k <= N; k++) begin
        if (g < 0 && m_pend[(m_last + k) % N] != 0) g = (m_last + k) % N;
      end
      m_top = 0; m_tsrc = 0;
      if (g >= 0) begin
        m_tsrc = g; m_last = g; m_pend[g] = 0; m_done[g] = 1;
        if (m_wr[g] != 0) begin
          if (m_st[g] == 2) begin
            m_top = 3; m_data[g] = m_wd[g];
          end else begin
            m_top = 2;
            for (int i = 0; i < N; i++) m_st[i] = 0;
            m_st[g] = 2; m_data[g] = m_wd[g];
          end
        end else if (m_st[g] != 0) begin
          m_top = 3; m_rd[g] = m_data[g];
        end else begin
          m_top = 1; own = -1;
          for (int i = 0; i < N; i++) if (m_st[i] == 2) own = i;
          if (own >= 0) begin
            val = m_data[own]; m_mem = val; m_st[own] = 1;
          end else begin
            val = m_mem;
          end
          m_st[g] = 1; m_data[g] = val; m_rd[g] = val;
        end
      end
      for (int i = 0; i < N; i++) begin
        if (was_pend[i] == 0 && req_valid[i]) begin
          m_pend[i] = 1; m_wr[i] = int'(req_write[i]);
          m_wd[i] = int'(req_wdata[i*DW +: DW]);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < N; i++) begin
        chk(busy[i] == m_pend[i][0], "R2 busy", int'(busy[i]), m_pend[i]);
        chk(done[i] == m_done[i][0], "R2 done", int'(done[i]), m_done[i]);
        chk(int'(rd_data[i*DW +: DW]) == m_rd[i], "R9 rd_data",
            int'(rd_data[i*DW +: DW]), m_rd[i]);
      end
      chk(int'(trace_op) == m_top, "R3 R4 trace_op", int'(trace_op), m_top);
      chk(int'(trace_src) == m_tsrc, "R8 trace_src", int'(trace_src), m_tsrc);
      chk(int'(mem_data) == m_mem, "R6 mem_data", int'(mem_data), m_mem);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input int c, input bit wr, input int wd,
                        output int op, output int rd);
    @(negedge clk);
    req_valid[c] = 1'b1;
    req_write[c] = wr;
    req_wdata[c*DW +: DW] = DW'(wd);
    @(negedge clk);
    req_valid[c] = 1'b0;
    while (!done[c]) @(negedge clk);
    op = int'(trace_op);
    rd = int'(rd_data[c*DW +: DW]);
  endtask

  int op, rd;
  int order[4];

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == '0 && done == '0, "R1 busy/done", int'({busy, done}), 0);
    chk(trace_op == 2'd0 && trace_src == '0, "R1 trace", int'(trace_op), 0);
    chk(mem_data == '0 && rd_data == '0, "R1 mem/rd", int'(mem_data), 0);

    run_op(0, 1'b0, 0, op, rd);
    chk(op == 1, "R3 read miss core0", op, 1);
    chk(rd == 0, "R7 data from memory", rd, 0);
    run_op(1, 1'b0, 0, op, rd);
    chk(op == 1, "R3 read miss core1", op, 1);
    run_op(0, 1'b0, 0, op, rd);
    chk(op == 3, "R3 read hit local", op, 3);
    run_op(0, 1'b1, 8'h11, op, rd);
    chk(op == 2, "R4 write from shared invalidates", op, 2);
    run_op(1, 1'b0, 0, op, rd);
    chk(op == 1, "R5 invalidated copy misses", op, 1);
    chk(rd == 8'h11, "R6 owner supplies data", rd, 8'h11);
    chk(int'(mem_data) == 8'h11, "R6 memory refreshed", int'(mem_data), 8'h11);
    run_op(0, 1'b1, 8'h22, op, rd);
    chk(op == 2, "R6 former owner now shared", op, 2);
    run_op(0, 1'b1, 8'h33, op, rd);
    chk(op == 3, "R4 write on modified is local", op, 3);
    run_op(2, 1'b1, 8'h44, op, rd);
    chk(op == 2, "R4 write miss invalidates", op, 2);
    chk(int'(mem_data) == 8'h11, "R10 dirty copy discarded", int'(mem_data), 8'h11);
    run_op(0, 1'b0, 0, op, rd);
    chk(op == 1, "R11 overtaken owner misses", op, 1);
    chk(rd == 8'h44, "R9 latest write returned", rd, 8'h44);

    // R8 simultaneous requests after core0 was last granted
    @(negedge clk);
    req_valid = '1;
    req_write = '0;
    @(negedge clk);
    req_valid = '0;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      order[s] = -1;
      for (int i = 0; i < N; i++) if (done[i]) order[s] = i;
    end
    chk(order[0] == 1, "R8 first grant", order[0], 1);
    chk(order[1] == 2, "R8 second grant", order[1], 2);
    chk(order[2] == 3, "R8 third grant", order[2], 3);
    chk(order[3] == 0, "R8 wrap grant", order[3], 0);

    // mixed traffic compared cycle by cycle against the model (R2..R11)
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        req_valid[i] = !busy[i] && ($urandom % 3 == 0);
        req_write[i] = ($urandom % 2 == 0);
        req_wdata[i*DW +: DW] = DW'($urandom);
      end
    end
    @(negedge clk);
    req_valid = '0;
    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule